// File: doc/BRIEF.md
# Triggered Counting Delay Generator

The block delays one incoming trigger by a programmable number of ticks. The tick source is not free-running. It is a clock-enable divider that restarts on the clock edge that accepts the trigger, so every tick is in a fixed phase relation to that edge. A preset counter counts the ticks. Its low bits come from a user setting and its high bits are fixed by a parameter. When the counter reaches its last tick, the block issues a one-cycle delayed pulse, reloads the counter and returns to idle. It is then ready to accept the next trigger.

While a delay is running the block is busy. Any trigger edge that arrives in that time is dropped, so the dead time equals the programmed delay. The terminal event also clocks two coincidence samplers. Each sampler captures a slow gate input at the instant of the delayed edge. The gate therefore counts only if it is asserted before that edge and still asserted when the edge occurs. Each captured result is held until the next delayed edge.

Top module: `trig_delay_gen`

## Requirements
- R1: During and directly after reset, `delayed_out`, `busy` and both `coinc_out` bits are 0.
- R2: A rising edge of `trig_in` is one cycle with `trig_in` high after a cycle with it low. Such an edge, seen while `busy` is 0, sets `busy` at the next clock edge. That clock edge is the acceptance edge.
- R3: The count is N = {FIXED_HI, preset_lo}. The default FIXED_HI is 0, so N equals `preset_lo`. `delayed_out` rises exactly N*TICK_DIV clock cycles after the acceptance edge. The default TICK_DIV is 4.
- R4: A count value of zero is treated as 2^CNT_W ticks, which is 256 with the defaults. It never gives a zero-length delay.
- R5: `delayed_out` is high for exactly one cycle. `busy` falls on the same clock edge that raises `delayed_out`, and at no other time.
- R6: Trigger edges that arrive while `busy` is 1 are ignored. They produce no extra delayed pulse and do not restart or stretch the running delay.
- R7: A trigger held high counts as one event. It is not accepted again when the block goes idle while the trigger is still high.
- R8: On the edge that raises `delayed_out`, `coinc_out[i]` takes the value that `gate_in[i]` had in the cycle before that edge. A gate that drops one cycle earlier is captured as 0.
- R9: `coinc_out` holds its value between delayed pulses.
- R10: A trigger edge presented in the first cycle after `delayed_out` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Trigger; its rising edge starts a delay |
| preset_lo | input | SET_W (4) | User-set low bits of the count |
| gate_in | input | NCH (2) | Slow gate inputs for the coincidence channels |
| delayed_out | output | 1 | One-cycle delayed pulse |
| busy | output | 1 | High while a delay is in progress |
| coinc_out | output | NCH (2) | Held coincidence result per channel |

## Verification
The assertions check on every cycle that the delayed pulse is one cycle wide and that `busy` ends only with that pulse. They also check that the coincidence outputs change only on that pulse and then equal the gate inputs sampled just before it. A cycle counter compares the length of each busy period against the count latched at its start. The bench scenarios are needed for the rest: triggers rejected during the dead time, a held trigger not retriggering, the zero-count case, re-arming right after the pulse, and a gate dropping one cycle before or one cycle after the delayed edge.

// File: rtl/dly_pkg.sv
// Package: shared types and helpers for the triggered delay generator.
// Assumes count widths no larger than DLY_MAX_W bits.
package dly_pkg;

    localparam int unsigned DLY_MAX_W = 16;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_BUSY = 1'b1
    } arm_state_t;

    // Resolve a raw count of width w: zero stands for the full range 2^w.
    function automatic logic [DLY_MAX_W:0] full_count(
        input logic [DLY_MAX_W-1:0] raw,
        input int unsigned          w
    );
        logic [DLY_MAX_W:0] res;
        if (raw == '0) begin
            res = '0;
            res[w] = 1'b1;
        end else begin
            res = {1'b0, raw};
        end
        return res;
    endfunction

endpackage

// File: rtl/dly_trig_arm.sv
// Trigger arming: detects rising edges of the trigger and holds the busy
// latch from acceptance until the terminal event. Edges that arrive while
// the latch is set are dropped. Assumes trig_in is already synchronous.
module dly_trig_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic term,
    output logic accept,
    output logic busy
);
    import dly_pkg::*;

    logic       trig_q;
    arm_state_t state;

    // Edge seen while idle is accepted.
    assign accept = trig_in && !trig_q && (state == ARM_IDLE);
    assign busy   = (state == ARM_BUSY);

    // Remember the previous trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    // Busy latch: set on acceptance, cleared by the terminal event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARM_IDLE;
        end else begin
            case (state)
                ARM_IDLE: if (accept) state <= ARM_BUSY;
                ARM_BUSY: if (term)   state <= ARM_IDLE;
                default:              state <= ARM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dly_tick_gen.sv
// Gated tick source: a clock-enable divider that runs only while busy and
// restarts on acceptance. The first tick comes TICK_DIV cycles after the
// acceptance edge. Assumes TICK_DIV >= 1.
module dly_tick_gen #(
    parameter int unsigned TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (TICK_DIV == 1) begin : g_direct
            // Every running cycle is a tick.
            assign tick = run;
        end else begin : g_div
            localparam int unsigned DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

            logic [DIV_W-1:0] phase;

            assign tick = run && (phase == LAST);

            // Phase counter, restarted in step with the accepted trigger.
            always_ff @(posedge clk) begin
                if (!rst_n)          phase <= '0;
                else if (restart)    phase <= '0;
                else if (run) begin
                    if (phase == LAST) phase <= '0;
                    else               phase <= phase + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dly_preset_counter.sv
// Preset tick counter: loads {FIXED_HI, preset_lo} on acceptance and counts
// ticks down. The tick that finds one left is the terminal event, which
// also reloads the counter. A zero preset gives 2^CNT_W ticks.
module dly_preset_counter #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned SET_W    = 4,
    parameter logic [CNT_W-SET_W-1:0] FIXED_HI = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [SET_W-1:0] preset_lo,
    output logic             term
);
    import dly_pkg::*;

    localparam int unsigned REM_W = CNT_W + 1;

    logic [CNT_W-1:0]   raw;
    logic [REM_W-1:0]   load_val;
    logic [DLY_MAX_W:0] resolved;
    logic [REM_W-1:0]   remain;

    // Compose the count from the fixed high bits and the user bits.
    always_comb begin
        raw      = {FIXED_HI, preset_lo};
        resolved = full_count(DLY_MAX_W'(raw), CNT_W);
        load_val = resolved[REM_W-1:0];
    end

    assign term = tick && (remain == REM_W'(1));

    // Load on acceptance, reload at terminal count, otherwise count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain <= '0;
        else if (load || term)  remain <= load_val;
        else if (tick)          remain <= remain - 1'b1;
    end

endmodule

// File: rtl/dly_coinc_sampler.sv
// Coincidence samplers: one flop per channel captures its gate on the
// terminal event and holds the result until the next one.
module dly_coinc_sampler #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [NCH-1:0] gate_in,
    output logic [NCH-1:0] coinc
);
    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            // Capture this channel's gate on the delayed edge.
            always_ff @(posedge clk) begin
                if (!rst_n)      coinc[ch] <= 1'b0;
                else if (strobe) coinc[ch] <= gate_in[ch];
            end
        end
    endgenerate

endmodule

// File: rtl/trig_delay_gen.sv
// Top: triggered counting delay generator with coincidence stage.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module trig_delay_gen #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned SET_W    = 4,
    parameter logic [CNT_W-SET_W-1:0] FIXED_HI = '0,
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned NCH      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [SET_W-1:0] preset_lo,
    input  logic [NCH-1:0]   gate_in,
    output logic             delayed_out,
    output logic             busy,
    output logic [NCH-1:0]   coinc_out
);
    logic accept;
    logic tick;
    logic term;

    dly_trig_arm i_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .term    (term),
        .accept  (accept),
        .busy    (busy)
    );

    dly_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (accept),
        .tick    (tick)
    );

    dly_preset_counter #(
        .CNT_W    (CNT_W),
        .SET_W    (SET_W),
        .FIXED_HI (FIXED_HI)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tick      (tick),
        .preset_lo (preset_lo),
        .term      (term)
    );

    dly_coinc_sampler #(.NCH(NCH)) i_coinc (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (term),
        .gate_in (gate_in),
        .coinc   (coinc_out)
    );

    // Register the terminal event as the one-cycle delayed pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) delayed_out <= 1'b0;
        else        delayed_out <= term;
    end

endmodule

// File: rtl/dly_checker.sv
// Checker for trig_delay_gen, attached by bind. Measures each busy period
// with a counter and compares it to the count latched at its start.
module dly_checker #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned SET_W    = 4,
    parameter logic [CNT_W-SET_W-1:0] FIXED_HI = '0,
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned NCH      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_in,
    input logic [SET_W-1:0] preset_lo,
    input logic [NCH-1:0]   gate_in,
    input logic             delayed_out,
    input logic             busy,
    input logic [NCH-1:0]   coinc_out
);
    logic             trig_prev;
    logic [31:0]      run_len;
    logic [SET_W-1:0] p_lat;
    logic [31:0]      exp_len;

    // Track the trigger level, the busy length and the count in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_prev <= 1'b0;
            run_len   <= '0;
            p_lat     <= '0;
        end else begin
            trig_prev <= trig_in;
            run_len   <= busy ? run_len + 1 : '0;
            if (busy && run_len == 0) p_lat <= preset_lo;
        end
    end

    // Expected busy length from the count latched at the start of the delay.
    always_comb begin
        if ({FIXED_HI, p_lat} == '0) exp_len = (32'd1 << CNT_W) * TICK_DIV;
        else exp_len = 32'({FIXED_HI, p_lat}) * TICK_DIV;
    end

    // R2
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && !trig_prev && !busy) |=> busy);

    // R3 R4
    delay_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delayed_out |-> (run_len == exp_len));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delayed_out |=> !delayed_out);

    // R5
    busy_ends_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy ##1 !busy) |-> delayed_out);

    // R8
    coinc_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delayed_out |-> (coinc_out == $past(gate_in)));

    // R9
    coinc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !delayed_out |-> $stable(coinc_out));

endmodule

bind trig_delay_gen dly_checker #(
    .CNT_W    (CNT_W),
    .SET_W    (SET_W),
    .FIXED_HI (FIXED_HI),
    .TICK_DIV (TICK_DIV),
    .NCH      (NCH)
) i_dly_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_in     (trig_in),
    .preset_lo   (preset_lo),
    .gate_in     (gate_in),
    .delayed_out (delayed_out),
    .busy        (busy),
    .coinc_out   (coinc_out)
);

// File: tb/test_trig_delay_gen.sv
// Scoreboard bench: the driver pushes the expected pulse cycle and
// coincidence value; the monitor pops and compares on each delayed pulse.
module test_trig_delay_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int       cyc;
        logic [1:0] co;
        string    tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic [3:0] preset_lo = 4'd0;
    logic [1:0] gate_in = 2'b00;
    logic       delayed_out;
    logic       busy;
    logic [1:0] coinc_out;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    exp_t sb[$];

    trig_delay_gen i_trig_delay_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .preset_lo   (preset_lo),
        .gate_in     (gate_in),
        .delayed_out (delayed_out),
        .busy        (busy),
        .coinc_out   (coinc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int ticks(input logic [3:0] p);
        return (p == 4'd0) ? 256 : int'(p);
    endfunction

    // Monitor: every delayed pulse must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && delayed_out) begin
            if (sb.size() == 0) begin
                check("R6 spurious pulse", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R3 pulse cycle"}, cyc, e.cyc);
                check({e.tag, " R8 coinc"}, int'(coinc_out), int'(e.co));
            end
        end
    end

    // Driver: raise the trigger for one cycle and record the expected pulse.
    task automatic launch(input logic [3:0] p, input logic [1:0] co,
                          input string tag, output int exp_cyc);
        exp_t e;
        preset_lo = p;
        trig_in   = 1'b1;
        exp_cyc   = cyc + 1 + ticks(p) * TICK_DIV;
        e.cyc = exp_cyc; e.co = co; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        check({tag, " R2 busy after accept"}, int'(busy), 1);
        trig_in = 1'b0;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain;
        while (busy || sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ec;
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1 delayed_out in reset", int'(delayed_out), 0);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 coinc in reset", int'(coinc_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);

        // R3 basic delays with several gate patterns
        gate_in = 2'b01;
        launch(4'd3, 2'b01, "R3 p3", ec);
        drain();
        check("R9 coinc held", int'(coinc_out), 1);
        gate_in = 2'b10;
        launch(4'd1, 2'b10, "R3 p1", ec);
        drain();
        gate_in = 2'b11;
        launch(4'd15, 2'b11, "R3 p15", ec);
        drain();

        // R4 zero preset means 256 ticks
        gate_in = 2'b00;
        launch(4'd0, 2'b00, "R4 p0", ec);
        drain();

        // R6 triggers during busy are ignored and do not restart the delay
        gate_in = 2'b01;
        launch(4'd6, 2'b01, "R6 dead", ec);
        repeat (5) @(negedge clk);
        trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
        repeat (7) @(negedge clk);
        trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
        check("R6 still busy", int'(busy), 1);
        drain();
        check("R6 no extra pulse", sb.size(), 0);

        // R10 re-arm in the first cycle after the delayed pulse
        launch(4'd2, 2'b01, "R10 first", ec);
        wait_cyc(ec);
        check("R5 busy low with pulse", int'(busy), 0);
        launch(4'd2, 2'b01, "R10 rearm", ec);
        check("R5 pulse one cycle", int'(delayed_out), 0);
        drain();

        // R7 a held trigger counts once
        preset_lo = 4'd2;
        trig_in = 1'b1;
        begin
            exp_t e;
            e.cyc = cyc + 1 + 2 * TICK_DIV; e.co = 2'b01; e.tag = "R7 held";
            sb.push_back(e);
        end
        drain();
        repeat (10) @(negedge clk);
        check("R7 no retrigger", int'(busy), 0);
        trig_in = 1'b0;
        @(negedge clk);

        // R8 gate drops one cycle before the delayed edge -> captured 0
        gate_in = 2'b11;
        launch(4'd3, 2'b01, "R8 early drop", ec);
        wait_cyc(ec - 1);
        gate_in = 2'b01;
        drain();
        // R8 gate drops right after the delayed edge -> captured 1
        gate_in = 2'b11;
        launch(4'd3, 2'b11, "R8 late drop", ec);
        wait_cyc(ec);
        gate_in = 2'b00;
        repeat (3) @(negedge clk);
        check("R9 coinc held after gate drop", int'(coinc_out), 3);
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule